// File: doc/BRIEF.md
# Coarse-Fine Output Data-Rate Generator

This block turns a free-running reference clock into a periodic one-cycle strobe that marks each output data word. The period, counted in reference cycles, comes from two settings. A 3-bit coarse code selects an integer multiple of a 384-cycle step. An 11-bit fine value is scaled by a fractional factor, and the coarse code also selects that factor. The two terms are added and any fraction is dropped, which gives an integer divider.

Both factor tables are held inside the block as parameters. The computed divider is loaded into the period counter only when a period ends, so a new setting never cuts short the period in progress. A synchronous restart input starts a fresh period at once. The divider now in force is visible on an output, so the surrounding logic can track the current rate.

Top module: `rate_gen`

## Requirements
- R1: While rst_ni is low, strobe_o is 0 and divider_o is 0, and both take these values as soon as rst_ni falls, with no clock edge needed.
- R2: The divider is D = K[c]*384 + floor(Q[c]*f/16), where c is coarse_i, f is fine_i, K indexed 0..7 is {0,1,2,3,4,6,8,12} and Q indexed 0..7 is {1,2,4,6,8,12,16,24}. Each Q entry is a value with 4 fractional bits. After a load, divider_o shows D.
- R3: A divider that works out below 2 is raised to 2. For example, coarse 0 with fine 0..47 gives 2.
- R4: strobe_o is high for exactly one clock cycle in every D cycles, and it is never high on two cycles in a row.
- R5: If coarse_i or fine_i changes during a period, that period's length and divider_o do not change. The next period uses the settings sampled on the clock edge that ends the strobe cycle.
- R6: restart_i is sampled on the rising clock edge and takes priority over the end-of-period reload. The edge that samples it loads D from the current settings and restarts the count at zero. Counting that edge as the first, strobe_o next goes high after the D-th rising edge, and strobe_o is low in the cycle that follows the restart edge.
- R7: The first rising edge after rst_ni is released loads D from the current settings, exactly as a restart would. The first strobe then follows after the D-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart of the period count |
| coarse_i | input | 3 | Coarse rate code |
| fine_i | input | 11 | Fine rate value |
| strobe_o | output | 1 | One-cycle output-data strobe |
| divider_o | output | 16 | Divider of the period now in force, 0 before the first load |

## Verification
The divider arithmetic is swept over every coarse and fine combination and compared with the formula. A design that rounded instead of truncating, picked the wrong table entry, or left out the lower clamp would report a wrong divider for some code. Strobe patterns are recorded cycle by cycle and compared against fixed expected positions in three situations: a settings change in mid-period, a restart in mid-period, and the first load after reset. A design that reloaded at once would cut a period short. A design that ignored the restart would strobe at the old boundary. A design with an off-by-one error in the count would move every strobe by one cycle.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int unsigned COARSE_W = 3;
  localparam int unsigned FINE_W   = 11;
  localparam int unsigned TAB_N    = 1 << COARSE_W;
  localparam int unsigned FACT_W   = 8;

  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [FINE_W-1:0]   fine_t;
  typedef logic [TAB_N-1:0][FACT_W-1:0] fact_tab_t;

  typedef struct packed {
    coarse_t coarse;
    fine_t   fine;
  } rate_cfg_t;
endpackage

// File: rtl/rate_div_calc.sv
module rate_div_calc
  import rate_gen_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BASE_STEP = 384,
  parameter int unsigned FRAC_W    = 4,
  parameter int unsigned MIN_DIV   = 2,
  parameter fact_tab_t   COARSE_TAB = '0,
  parameter fact_tab_t   FINE_TAB   = '0
) (
  input  rate_cfg_t        cfg_i,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned ACC_W = 32;
  localparam logic [ACC_W-1:0] DIV_MAX = ACC_W'((64'd1 << DIV_W) - 64'd1);

  logic [FACT_W-1:0] coarse_fac;
  logic [FACT_W-1:0] fine_fac;
  logic [ACC_W-1:0]  base_term;
  logic [ACC_W-1:0]  fine_prod;
  logic [ACC_W-1:0]  frac_term;
  logic [ACC_W-1:0]  raw_div;
  logic [ACC_W-1:0]  sat_div;

  assign coarse_fac = COARSE_TAB[cfg_i.coarse];
  assign fine_fac   = FINE_TAB[cfg_i.coarse];

  assign base_term = ACC_W'(coarse_fac) * ACC_W'(BASE_STEP);
  assign fine_prod = ACC_W'(fine_fac) * ACC_W'(cfg_i.fine);

  // fixed-point fine product, truncated toward zero
  generate
    if (FRAC_W == 0) begin : g_int_fine
      assign frac_term = fine_prod;
    end else begin : g_frac_fine
      assign frac_term = fine_prod >> FRAC_W;
    end
  endgenerate

  assign raw_div = base_term + frac_term;
  assign sat_div = (raw_div > DIV_MAX) ? DIV_MAX : raw_div;

  generate
    if (MIN_DIV > 0) begin : g_clamp
      assign div_o = (sat_div < ACC_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : sat_div[DIV_W-1:0];
    end else begin : g_noclamp
      assign div_o = sat_div[DIV_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rate_period_cnt.sv
module rate_period_cnt #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] next_div_i,
  output logic             strobe_o,
  output logic [DIV_W-1:0] active_div_o
);
  logic             armed_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             last_cyc;
  logic             load;

  assign last_cyc = armed_q && (cnt_q == div_q - DIV_W'(1));
  // restart and first cycle after reset preempt the boundary reload
  assign load     = restart_i || !armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      div_q   <= '0;
    end else if (load) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      div_q   <= next_div_i;
    end else if (last_cyc) begin
      cnt_q   <= '0;
      div_q   <= next_div_i;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end

  assign strobe_o     = last_cyc;
  assign active_div_o = div_q;
endmodule

// File: rtl/rate_gen.sv
module rate_gen
  import rate_gen_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned BASE_STEP  = 384,
  parameter int unsigned FRAC_W     = 4,
  parameter int unsigned MIN_DIV    = 2,
  parameter fact_tab_t   COARSE_TAB = {8'd12, 8'd8, 8'd6, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
  parameter fact_tab_t   FINE_TAB   = {8'd24, 8'd16, 8'd12, 8'd8, 8'd6, 8'd4, 8'd2, 8'd1}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                strobe_o,
  output logic [DIV_W-1:0]    divider_o
);
  rate_cfg_t        cfg;
  logic [DIV_W-1:0] next_div;

  assign cfg.coarse = coarse_i;
  assign cfg.fine   = fine_i;

  rate_div_calc #(
    .DIV_W     (DIV_W),
    .BASE_STEP (BASE_STEP),
    .FRAC_W    (FRAC_W),
    .MIN_DIV   (MIN_DIV),
    .COARSE_TAB(COARSE_TAB),
    .FINE_TAB  (FINE_TAB)
  ) u_calc (
    .cfg_i(cfg),
    .div_o(next_div)
  );

  rate_period_cnt #(
    .DIV_W(DIV_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .next_div_i  (next_div),
    .strobe_o    (strobe_o),
    .active_div_o(divider_o)
  );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned MIN_DIV = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             strobe_o,
  input logic [DIV_W-1:0] divider_o
);
  logic [DIV_W-1:0] gap_q;

  // cycles since the last load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      gap_q <= '0;
    else if (restart_i || strobe_o || divider_o == '0) gap_q <= DIV_W'(1);
    else                                              gap_q <= gap_q + DIV_W'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    strobe_o |-> divider_o != '0);

  p_min_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divider_o != '0) |-> (divider_o >= DIV_W'(MIN_DIV)));

  p_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  p_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (gap_q == divider_o));

  p_hold_div_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_o && !restart_i && divider_o != '0) |=> $stable(divider_o));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !strobe_o);

  p_first_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divider_o == '0) |=> (divider_o != '0));
endmodule

bind rate_gen rate_gen_chk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .restart_i(restart_i),
  .strobe_o (strobe_o),
  .divider_o(divider_o)
);

// File: tb/tb_rate_gen.sv
module tb_rate_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart_i = 1'b0;
  logic [2:0]  coarse_i = '0;
  logic [10:0] fine_i = '0;
  logic        strobe_o;
  logic [15:0] divider_o;

  int compared = 0;
  int mismatched = 0;

  always #4 clk_i = ~clk_i;

  rate_gen dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .coarse_i (coarse_i),
    .fine_i   (fine_i),
    .strobe_o (strobe_o),
    .divider_o(divider_o)
  );

  function automatic int exp_div(int c, int f);
    int kt[8] = '{0, 1, 2, 3, 4, 6, 8, 12};
    int qt[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
    int d;
    d = kt[c] * 384 + (qt[c] * f) / 16;
    if (d < 2) d = 2;
    return d;
  endfunction

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // restart with (c,f), then compare strobe against k%D over n periods
  task automatic run_periods(int c, int f, int n);
    int d;
    int errs;
    d = exp_div(c, f);
    errs = 0;
    @(negedge clk_i);
    coarse_i = 3'(c); fine_i = 11'(f); restart_i = 1'b1;
    for (int k = 1; k <= n * d; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        restart_i = 1'b0;
        check("R2/R6 divider after restart", int'(divider_o), d);
      end
      if (strobe_o != ((k % d) == 0)) errs++;
    end
    check("R4 strobe pattern", errs, 0);
  endtask

  initial begin
    int errs;
    // R1: held in reset
    coarse_i = 3'd0; fine_i = 11'd80;
    repeat (3) @(negedge clk_i);
    check("R1 strobe in reset", int'(strobe_o), 0);
    check("R1 divider in reset", int'(divider_o), 0);
    rst_ni = 1'b1;
    // R7: first edge after release loads D=5
    errs = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      if (k == 1) check("R7 first load divider", int'(divider_o), 5);
      if (strobe_o != (k == 5 || k == 10)) errs++;
    end
    check("R7 first strobes", errs, 0);

    // R2/R3: exhaustive divider sweep
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 2048; f++) begin
        @(negedge clk_i);
        coarse_i = 3'(c); fine_i = 11'(f); restart_i = 1'b1;
        @(negedge clk_i);
        check($sformatf("R2/R3 divider c=%0d f=%0d", c, f), int'(divider_o), exp_div(c, f));
      end
    end
    restart_i = 1'b0;

    // R3/R4: clamped and ordinary periods
    run_periods(0, 0, 4);
    run_periods(0, 47, 3);
    run_periods(0, 48, 3);
    run_periods(3, 3, 2);
    run_periods(2, 2047, 2);

    // R5: changes mid-period take effect at the next boundary
    errs = 0;
    @(negedge clk_i);
    coarse_i = 3'd1; fine_i = 11'd0; restart_i = 1'b1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk_i);
      if (k == 1) restart_i = 1'b0;
      if (k == 3) begin coarse_i = 3'd0; fine_i = 11'd100; end
      if (k == 200) check("R5 divider held mid-period", int'(divider_o), 384);
      if (k == 385) check("R5 divider after boundary", int'(divider_o), 6);
      if (k == 386) begin coarse_i = 3'd0; fine_i = 11'd64; end
      if (strobe_o != (k == 384 || k == 390 || k == 394 || k == 398)) errs++;
    end
    check("R5 strobe positions", errs, 0);

    // R6: restart mid-period restarts the count
    errs = 0;
    @(negedge clk_i);
    coarse_i = 3'd0; fine_i = 11'd96; restart_i = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk_i);
      if (k == 1) restart_i = 1'b0;
      if (k == 3) restart_i = 1'b1;
      if (k == 4) restart_i = 1'b0;
      if (strobe_o != (k == 9 || k == 15)) errs++;
    end
    check("R6 strobe after mid restart", errs, 0);

    // R6: restart in the strobe cycle
    errs = 0;
    @(negedge clk_i);
    coarse_i = 3'd0; fine_i = 11'd64; restart_i = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_i);
      if (k == 1) restart_i = 1'b0;
      if (k == 4) begin
        coarse_i = 3'd0; fine_i = 11'd96; restart_i = 1'b1;
      end
      if (k == 5) begin
        restart_i = 1'b0;
        check("R6 divider after restart at strobe", int'(divider_o), 6);
      end
      if (strobe_o != (k == 4 || k == 10)) errs++;
    end
    check("R6 strobe after restart at strobe", errs, 0);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset divider", int'(divider_o), 0);
    check("R1 async reset strobe", int'(strobe_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule